// File: doc/BRIEF.md
# Program-Memory Window Decoder

This block sits between a CPU's write bus and a program-memory array that is split into 8 KiB pages. It watches CPU writes and keeps a page number for each of four switchable windows: one at 0x6000 and three at 0x8000, 0xA000 and 0xC000. The window at 0xE000 is fixed to the highest page. A separate register holds a 2-bit nametable mirroring mode for the video side.

On the read side, the block turns a 16-bit CPU address into a flat program-memory address. That address is the selected page number joined with the 13-bit offset inside the page. It also raises a hit flag when the address falls inside 0x6000 to 0xFFFF. Both results are registered, so they appear one clock after the address is presented.

The decode has two unusual features. The page for the 0x6000 window comes from the low bits of the write address, not from the data byte. The three upper window registers also sit at addresses that do not match the windows they control.

Top module: `prg_window_map`

## Requirements
- R1: After synchronous reset, the four switchable windows select page 0, `mirror_mode` is 0 (vertical), `map_hit` is 0 and `map_addr` is 0.
- R2: A write whose address, masked with 0xF800, equals 0x6800 loads the 0x6000 window page from `wr_addr[5:0]`. The data byte has no effect on this load.
- R3: A write whose address, masked with 0xF80C, equals 0x8800 loads the 0x8000 window page from `wr_data`.
- R4: A write whose address, masked with 0xF80C, equals 0xA800 loads the 0xA000 window page from `wr_data`.
- R5: A write whose address, masked with 0xF80C, equals 0xA000 loads the 0xC000 window page from `wr_data`.
- R6: A read in 0xE000 to 0xFFFF always maps to page `PAGE_COUNT-1`.
- R7: A write whose address, masked with 0xF80C, equals 0x9800 sets `mirror_mode` to `wr_data[1:0]`. The encoding is 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper.
- R8: A read below 0x6000 gives `map_hit` = 0 and `map_addr` = 0.
- R9: Every loaded page number is reduced modulo `PAGE_COUNT` (default 32). For example, 37 selects page 5 and 63 selects page 31.
- R10: A write that matches none of the decodes leaves every window page and `mirror_mode` unchanged. Near-miss addresses such as 0x8804, 0x9808 and 0x6000 are included.
- R11: `map_addr` is `{page, rd_addr[12:0]}` and appears one clock after `rd_addr`. A write at clock edge E is seen by reads sampled at edge E+1 and later, but not by a read sampled at edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address to translate |
| map_addr | output | PAGE_W+13 | Translated program-memory address, registered |
| map_hit | output | 1 | Read address lies in 0x6000 to 0xFFFF, registered |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
Each result has a fixed latency:
- A page or mirror write takes effect at the clock edge that samples `wr_en`.
- The translated address and hit flag appear at the edge after `rd_addr` is presented.
- A read therefore reflects a write only when it is presented after that write's edge.

The bench drives inputs on the falling edge. For a mirror result it samples one falling edge after the write. For a translation result it samples one falling edge after presenting the read address. A dedicated case presents a write and a read in the same cycle, then checks that the old page appears first and the new page follows one clock later.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int unsigned CPU_AW     = 16;
    localparam int unsigned CPU_DW     = 8;
    localparam int unsigned PAGE_OFS_W = 13;
    localparam int unsigned NUM_SW     = 4;

    // Write decode constants
    localparam logic [CPU_AW-1:0] LOWWIN_MASK  = 16'hF800;
    localparam logic [CPU_AW-1:0] LOWWIN_MATCH = 16'h6800;
    localparam logic [CPU_AW-1:0] REG_MASK     = 16'hF80C;
    localparam logic [CPU_AW-1:0] REG_WIN8     = 16'h8800;
    localparam logic [CPU_AW-1:0] REG_WINA     = 16'hA800;
    localparam logic [CPU_AW-1:0] REG_WINC     = 16'hA000;
    localparam logic [CPU_AW-1:0] REG_MIRROR   = 16'h9800;

    typedef enum logic [1:0] {
        MIR_VERTICAL   = 2'd0,
        MIR_HORIZONTAL = 2'd1,
        MIR_SINGLE_LO  = 2'd2,
        MIR_SINGLE_HI  = 2'd3
    } mirror_e;

    typedef enum logic [2:0] {
        WR_NONE    = 3'd0,
        WR_LOW_WIN = 3'd1,
        WR_WIN_8   = 3'd2,
        WR_WIN_A   = 3'd3,
        WR_WIN_C   = 3'd4,
        WR_MIRROR  = 3'd5
    } wr_target_e;

    typedef struct packed {
        wr_target_e          target;
        logic [CPU_DW-1:0]   value;
    } wr_cmd_t;

    // Switchable window index -> the write target that loads it.
    // Index 0 is the 0x6000 window, 1..3 are 0x8000, 0xA000, 0xC000.
    function automatic wr_target_e sw_target(input int unsigned idx);
        case (idx)
            0:       return WR_LOW_WIN;
            1:       return WR_WIN_8;
            2:       return WR_WIN_A;
            default: return WR_WIN_C;
        endcase
    endfunction

    function automatic logic [CPU_DW-1:0] wrap_page(input logic [CPU_DW-1:0] v,
                                                    input int unsigned n);
        return CPU_DW'(32'(v) % n);
    endfunction

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
    import prg_map_pkg::*;
(
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [CPU_DW-1:0] wr_data,
    output wr_cmd_t           cmd
);

    logic [CPU_AW-1:0] reg_key;

    always_comb begin
        reg_key      = wr_addr & REG_MASK;
        cmd.target   = WR_NONE;
        cmd.value    = wr_data;
        if (wr_en) begin
            if ((wr_addr & LOWWIN_MASK) == LOWWIN_MATCH) begin
                cmd.target = WR_LOW_WIN;
                cmd.value  = {2'b00, wr_addr[5:0]};
            end else begin
                case (reg_key)
                    REG_WIN8:   cmd.target = WR_WIN_8;
                    REG_WINA:   cmd.target = WR_WIN_A;
                    REG_WINC:   cmd.target = WR_WIN_C;
                    REG_MIRROR: cmd.target = WR_MIRROR;
                    default:    cmd.target = WR_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_map_pkg::*;
#(
    parameter int unsigned PAGE_COUNT = 32,
    parameter int unsigned PAGE_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_cmd_t                       cmd,
    output logic [NUM_SW-1:0][PAGE_W-1:0] pages,
    output mirror_e                       mirror
);

    logic [PAGE_W-1:0] load_page;

    assign load_page = PAGE_W'(wrap_page(cmd.value, PAGE_COUNT));

    for (genvar i = 0; i < NUM_SW; i++) begin : g_win
        logic [PAGE_W-1:0] pg_q;
        always_ff @(posedge clk) begin
            if (rst)
                pg_q <= '0;
            else if (cmd.target == sw_target(i))
                pg_q <= load_page;
        end
        assign pages[i] = pg_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mirror <= MIR_VERTICAL;
        else if (cmd.target == WR_MIRROR)
            mirror <= mirror_e'(cmd.value[1:0]);
    end

endmodule

// File: rtl/prg_addr_xlate.sv
module prg_addr_xlate
    import prg_map_pkg::*;
#(
    parameter int unsigned PAGE_COUNT = 32,
    parameter int unsigned PAGE_W     = 5,
    localparam int unsigned MAP_AW    = PAGE_W + PAGE_OFS_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CPU_AW-1:0]             rd_addr,
    input  logic [NUM_SW-1:0][PAGE_W-1:0] pages,
    output logic [MAP_AW-1:0]             map_addr,
    output logic                          map_hit
);

    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

    logic [PAGE_W-1:0] sel_page;
    logic              sel_hit;

    always_comb begin
        sel_page = '0;
        sel_hit  = 1'b1;
        case (rd_addr[15:13])
            3'd3:    sel_page = pages[0];
            3'd4:    sel_page = pages[1];
            3'd5:    sel_page = pages[2];
            3'd6:    sel_page = pages[3];
            3'd7:    sel_page = LAST_PAGE;
            default: sel_hit  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_addr <= '0;
            map_hit  <= 1'b0;
        end else begin
            map_hit  <= sel_hit;
            map_addr <= sel_hit ? {sel_page, rd_addr[PAGE_OFS_W-1:0]} : '0;
        end
    end

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_map_pkg::*;
#(
    parameter int unsigned PAGE_COUNT = 32,
    localparam int unsigned PAGE_W    = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1,
    localparam int unsigned MAP_AW    = PAGE_W + PAGE_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       rd_addr,
    output logic [MAP_AW-1:0] map_addr,
    output logic              map_hit,
    output logic [1:0]        mirror_mode
);

    wr_cmd_t                       cmd;
    logic [NUM_SW-1:0][PAGE_W-1:0] pages;
    mirror_e                       mirror;

    prg_wr_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    prg_bank_regs #(
        .PAGE_COUNT (PAGE_COUNT),
        .PAGE_W     (PAGE_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .pages  (pages),
        .mirror (mirror)
    );

    prg_addr_xlate #(
        .PAGE_COUNT (PAGE_COUNT),
        .PAGE_W     (PAGE_W)
    ) u_xlate (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (rd_addr),
        .pages    (pages),
        .map_addr (map_addr),
        .map_hit  (map_hit)
    );

    assign mirror_mode = mirror;

endmodule

// File: rtl/prg_window_map_chk.sv
module prg_window_map_chk #(
    parameter int unsigned PAGE_COUNT = 32,
    parameter int unsigned PAGE_W     = 5,
    parameter int unsigned MAP_AW     = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [7:0]        wr_data,
    input logic [15:0]       rd_addr,
    input logic [MAP_AW-1:0] map_addr,
    input logic              map_hit,
    input logic [1:0]        mirror_mode
);

    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

    logic mirror_wr;
    assign mirror_wr = wr_en && ((wr_addr & 16'hF80C) == 16'h9800);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (mirror_mode == 2'd0) && !map_hit && (map_addr == '0));

    p_fixed_last_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[15:13] == 3'd7) |=> map_hit && (map_addr[MAP_AW-1:13] == LAST_PAGE));

    p_mirror_load_r7: assert property (@(posedge clk) disable iff (rst)
        mirror_wr |=> (mirror_mode == $past(wr_data[1:0])));

    p_outside_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[15:13] < 3'd3) |=> !map_hit && (map_addr == '0));

    p_mirror_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !mirror_wr |=> $stable(mirror_mode));

    p_offset_pass_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[15:13] >= 3'd3) |=> map_hit && (map_addr[12:0] == $past(rd_addr[12:0])));

endmodule

bind prg_window_map prg_window_map_chk #(
    .PAGE_COUNT (PAGE_COUNT),
    .PAGE_W     (PAGE_W),
    .MAP_AW     (MAP_AW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .map_addr    (map_addr),
    .map_hit     (map_hit),
    .mirror_mode (mirror_mode)
);

// File: tb/test_prg_window_map.sv
module test_prg_window_map;

    localparam int unsigned PAGE_COUNT = 32;
    localparam int unsigned PAGE_W     = 5;
    localparam int unsigned MAP_AW     = PAGE_W + 13;
    localparam int unsigned NVEC       = 13;

    typedef struct packed {
        logic [15:0] wa;
        logic [7:0]  wd;
        logic [15:0] ra;
        logic [7:0]  pg;
        logic        hit;
        logic [1:0]  mir;
    } vec_t;

    // Cumulative sequence: write, then read; expected page before wrap.
    localparam vec_t VEC [NVEC] = '{
        '{16'h8800, 8'h07, 16'h8123, 8'd7,  1'b1, 2'd0}, // R3
        '{16'hA800, 8'h0A, 16'hA456, 8'd10, 1'b1, 2'd0}, // R4
        '{16'hA000, 8'h11, 16'hC001, 8'd17, 1'b1, 2'd0}, // R5
        '{16'h6805, 8'hFF, 16'h7FFF, 8'd5,  1'b1, 2'd0}, // R2 data ignored
        '{16'h9800, 8'h01, 16'hE000, 8'd31, 1'b1, 2'd1}, // R7 horizontal, R6
        '{16'h9800, 8'h02, 16'h8000, 8'd7,  1'b1, 2'd2}, // R7 single lower
        '{16'h9800, 8'h07, 16'hFFFF, 8'd31, 1'b1, 2'd3}, // R7 data[1:0]=3, R6
        '{16'h8800, 8'h25, 16'h9FFF, 8'd37, 1'b1, 2'd3}, // R9 37 -> 5
        '{16'h683F, 8'h00, 16'h6000, 8'd63, 1'b1, 2'd3}, // R9 R2 63 -> 31
        '{16'h8804, 8'h03, 16'h8000, 8'd37, 1'b1, 2'd3}, // R10 near miss
        '{16'h9808, 8'h00, 16'hC000, 8'd17, 1'b1, 2'd3}, // R10 near miss mirror
        '{16'h1234, 8'h99, 16'h4000, 8'd0,  1'b0, 2'd3}, // R8 R10
        '{16'h6000, 8'h01, 16'h0000, 8'd0,  1'b0, 2'd3}  // R8 R10 low window miss
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [15:0]       rd_addr = '0;
    logic [MAP_AW-1:0] map_addr;
    logic              map_hit;
    logic [1:0]        mirror_mode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    prg_window_map #(.PAGE_COUNT(PAGE_COUNT)) i_prg_window_map (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .map_addr    (map_addr),
        .map_hit     (map_hit),
        .mirror_mode (mirror_mode)
    );

    function automatic logic [MAP_AW-1:0] exp_addr(input logic [15:0] ra,
                                                  input logic [7:0] pg,
                                                  input logic hit);
        logic [PAGE_W-1:0] p;
        p = PAGE_W'(32'(pg) % PAGE_COUNT);
        return hit ? {p, ra[12:0]} : '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [15:0] a,
                           input logic [7:0] pg, input logic hit);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        check(req, 32'(map_addr), 32'(exp_addr(a, pg, hit)));
        check(req, 32'(map_hit), 32'(hit));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 mirror", 32'(mirror_mode), 32'd0);
        check("R1 hit", 32'(map_hit), 32'd0);
        check("R1 addr", 32'(map_addr), 32'd0);
        do_read("R1 win6", 16'h6010, 8'd0, 1'b1);
        do_read("R1 win8", 16'h8010, 8'd0, 1'b1);
        do_read("R1 winA", 16'hA010, 8'd0, 1'b1);
        do_read("R1 winC", 16'hC010, 8'd0, 1'b1);
        do_read("R6 fixed", 16'hE010, 8'd31, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i].wa, VEC[i].wd);
            do_read($sformatf("vector %0d", i), VEC[i].ra, VEC[i].pg, VEC[i].hit);
            check($sformatf("vector %0d mirror", i), 32'(mirror_mode), 32'(VEC[i].mir));
        end

        // R10: all windows unchanged after the near-miss writes
        do_read("R10 win6", 16'h6000, 8'd31, 1'b1);
        do_read("R10 winA", 16'hA000, 8'd10, 1'b1);

        // R11: write and read in the same cycle
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 16'h8800;
        wr_data = 8'h09;
        rd_addr = 16'h8ABC;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 old page", 32'(map_addr), 32'(exp_addr(16'h8ABC, 8'd5, 1'b1)));
        @(negedge clk);
        check("R11 new page", 32'(map_addr), 32'(exp_addr(16'h8ABC, 8'd9, 1'b1)));

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 mirror after rerun", 32'(mirror_mode), 32'd0);
        do_read("R1 win6 rerun", 16'h7000, 8'd0, 1'b1);
        do_read("R1 win8 rerun", 16'h8000, 8'd0, 1'b1);
        do_read("R1 winA rerun", 16'hBFFF, 8'd0, 1'b1);
        do_read("R1 winC rerun", 16'hDFFF, 8'd0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule